// File: doc/BRIEF.md
# Camera Receiver Control and Status Registers

This block is the software-visible register file of a serial camera receiver. A host reaches it over a plain 32-bit single-cycle read/write bus addressed by byte offset. It holds the receiver's global control, the PHY lane and settle settings, the data-type and lane-count configuration, the image size and the interrupt mask and flags.

The configuration reaches the receiver core through a shadow stage. Programming a register does not disturb a running core. The new settings take effect together only when the host writes the shadow-update bit. The core reports events as single-cycle pulses. The block latches these pulses as sticky flags that the host clears by writing ones. The block raises one interrupt line while any flag is set and enabled in the mask. A self-timed soft reset clears the flags and the shadow outputs but keeps every programmed value.

Top module: `cam_rx_regfile`

## Requirements
- R1: After reset every register reads 0, `irq` and `core_rst` are low and all `rx_*` outputs are 0.
- R2: Only the implemented fields are stored and read back; other bits read 0. The implemented fields are: control at 0x00 (mask 0x80100101), PHY control at 0x04 (mask 0xF800001F), configuration at 0x08 (mask 0x000000FF), resolution at 0x2C (all bits) and interrupt mask at 0x10 (mask 0xF000103F). Any other offset reads 0 and ignores writes.
- R3: The `rx_*` outputs change only on a shadow update. Writing control bit 16 loads every output from the registers one cycle after the write. The field mapping is: `rx_enable`=ctrl[0], `rx_ext_clk`=ctrl[8], `rx_align32`=ctrl[20], `rx_pol_swap`=ctrl[31], `rx_lane_en`=phy[4:0], `rx_settle`=phy[31:27], `rx_dtype`=cfg[7:2], `rx_lanes_m1`=cfg[1:0], `rx_width`=res[31:16], `rx_height`=res[15:0].
- R4: Control bit 16 reads 1 in the cycle after it is written and clears itself one cycle later.
- R5: An `evt_in` pulse sets the matching flag of the interrupt source register at 0x14, whatever the mask holds. Only bits 0xF000F03F exist. The other bits read 0.
- R6: A write to 0x14 clears exactly the flags whose bit is 1 in the written word.
- R7: If an event and a clear hit the same flag in the same cycle, the flag stays set.
- R8: `irq` is high while any flag is set and its mask bit is set. Mask bit 12 enables the whole flag field 15:12.
- R9: Writing control bit 4 starts a soft reset. For 4 cycles, control bit 4 reads 1 and `core_rst` is high. During that time the flags, `irq` and all `rx_*` outputs are cleared. Programmed register values are kept.
- R10: Events that arrive during a soft reset are not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_in | input | 32 | Event pulses from the core, one bit per source flag |
| core_rst | output | 1 | Soft reset active |
| rx_enable | output | 1 | Shadowed receiver enable |
| rx_pol_swap | output | 1 | Shadowed differential polarity swap |
| rx_align32 | output | 1 | Shadowed 32-bit alignment (0 means 24-bit) |
| rx_ext_clk | output | 1 | Shadowed external wrapper clock select |
| rx_lane_en | output | 5 | Shadowed clock and data lane enables |
| rx_settle | output | 5 | Shadowed high-speed settle count |
| rx_dtype | output | 6 | Shadowed data-type code |
| rx_lanes_m1 | output | 2 | Shadowed lane count minus one |
| rx_width | output | 16 | Shadowed image width |
| rx_height | output | 16 | Shadowed image height |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that a shadow-update write is never followed at once by another shadow-update write. They also assume that each `evt_in` bit is a pulse sampled once per cycle. The stimulus keeps to both assumptions: every bus access is a single-cycle write followed by an idle cycle, and events are raised for exactly one cycle. The same-cycle event and clear case is the only point where an event overlaps a bus write. It is produced on purpose to test which of the two takes priority.

// File: rtl/cam_rx_pkg.sv
`timescale 1ns/1ps
package cam_rx_pkg;

    localparam int unsigned DW      = 32;
    localparam int unsigned LANE_W  = 5;
    localparam int unsigned SETTL_W = 5;
    localparam int unsigned DT_W    = 6;
    localparam int unsigned NL_W    = 2;
    localparam int unsigned DIM_W   = 16;

    // byte offsets
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_PHY  = 8'h04;
    localparam logic [7:0] OFS_CFG  = 8'h08;
    localparam logic [7:0] OFS_IMSK = 8'h10;
    localparam logic [7:0] OFS_ISRC = 8'h14;
    localparam logic [7:0] OFS_RES  = 8'h2C;

    // control bit positions
    localparam int unsigned CB_EN     = 0;
    localparam int unsigned CB_SRST   = 4;
    localparam int unsigned CB_EXTCLK = 8;
    localparam int unsigned CB_UPD    = 16;
    localparam int unsigned CB_ALIGN  = 20;
    localparam int unsigned CB_SWAP   = 31;

    // stored-field masks
    localparam logic [DW-1:0] CTRL_KEEP = 32'h8010_0101;
    localparam logic [DW-1:0] PHY_KEEP  = 32'hF800_001F;
    localparam logic [DW-1:0] CFG_KEEP  = 32'h0000_00FF;
    localparam logic [DW-1:0] IMSK_KEEP = 32'hF000_103F;
    localparam logic [DW-1:0] ISRC_IMPL = 32'hF000_F03F;

    typedef struct packed {
        logic               en;
        logic               swap;
        logic               align32;
        logic               extclk;
        logic [LANE_W-1:0]  lane_en;
        logic [SETTL_W-1:0] settle;
        logic [DT_W-1:0]    dtype;
        logic [NL_W-1:0]    lanes_m1;
        logic [DIM_W-1:0]   width;
        logic [DIM_W-1:0]   height;
    } cfg_t;

    // one mask bit (12) governs the four start-of-transmission flags 15:12
    function automatic logic [DW-1:0] expand_mask(logic [DW-1:0] m);
        logic [DW-1:0] r;
        r        = m & ~32'h0000_F000;
        r[15:12] = {4{m[12]}};
        return r;
    endfunction

    function automatic cfg_t gather_cfg(logic [DW-1:0] ctrl, logic [DW-1:0] phy,
                                        logic [DW-1:0] cfg, logic [DW-1:0] res);
        cfg_t c;
        c.en       = ctrl[CB_EN];
        c.swap     = ctrl[CB_SWAP];
        c.align32  = ctrl[CB_ALIGN];
        c.extclk   = ctrl[CB_EXTCLK];
        c.lane_en  = phy[LANE_W-1:0];
        c.settle   = phy[31:27];
        c.dtype    = cfg[7:2];
        c.lanes_m1 = cfg[1:0];
        c.width    = res[31:16];
        c.height   = res[15:0];
        return c;
    endfunction

endpackage

// File: rtl/cam_rx_bus_regs.sv
`timescale 1ns/1ps
module cam_rx_bus_regs
    import cam_rx_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SRST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     flags,
    output logic [DW-1:0]     bus_rdata,
    output cfg_t              live_cfg,
    output logic [DW-1:0]     imsk_q,
    output logic [DW-1:0]     clr_vec,
    output logic              upd_pend,
    output logic              srst_busy
);
    localparam int unsigned CNT_W = $clog2(SRST_CYCLES + 1);

    logic [DW-1:0]    ctrl_q, phy_q, cfg_q, res_q;
    logic [CNT_W-1:0] srst_cnt;
    logic             sel_ctrl, sel_phy, sel_cfg, sel_imsk, sel_isrc, sel_res;

    assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign sel_phy  = (bus_addr == ADDR_W'(OFS_PHY));
    assign sel_cfg  = (bus_addr == ADDR_W'(OFS_CFG));
    assign sel_imsk = (bus_addr == ADDR_W'(OFS_IMSK));
    assign sel_isrc = (bus_addr == ADDR_W'(OFS_ISRC));
    assign sel_res  = (bus_addr == ADDR_W'(OFS_RES));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            phy_q  <= '0;
            cfg_q  <= '0;
            res_q  <= '0;
            imsk_q <= '0;
        end else if (bus_wr) begin
            if (sel_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
            if (sel_phy)  phy_q  <= bus_wdata & PHY_KEEP;
            if (sel_cfg)  cfg_q  <= bus_wdata & CFG_KEEP;
            if (sel_res)  res_q  <= bus_wdata;
            if (sel_imsk) imsk_q <= bus_wdata & IMSK_KEEP;
        end
    end

    // action bits: shadow update pulse and self-timed soft reset
    always_ff @(posedge clk) begin
        if (rst) begin
            upd_pend <= 1'b0;
            srst_cnt <= '0;
        end else begin
            upd_pend <= bus_wr && sel_ctrl && bus_wdata[CB_UPD];
            if (bus_wr && sel_ctrl && bus_wdata[CB_SRST])
                srst_cnt <= CNT_W'(SRST_CYCLES);
            else if (srst_cnt != '0)
                srst_cnt <= srst_cnt - 1'b1;
        end
    end

    assign srst_busy = (srst_cnt != '0);
    assign clr_vec   = (bus_wr && sel_isrc) ? bus_wdata : '0;
    assign live_cfg  = gather_cfg(ctrl_q, phy_q, cfg_q, res_q);

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata           = ctrl_q;
            bus_rdata[CB_UPD]   = upd_pend;
            bus_rdata[CB_SRST]  = srst_busy;
        end
        if (sel_phy)  bus_rdata = phy_q;
        if (sel_cfg)  bus_rdata = cfg_q;
        if (sel_res)  bus_rdata = res_q;
        if (sel_imsk) bus_rdata = imsk_q;
        if (sel_isrc) bus_rdata = flags;
    end
endmodule

// File: rtl/cam_rx_shadow.sv
`timescale 1ns/1ps
module cam_rx_shadow
    import cam_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic srst_busy,
    input  logic upd_pend,
    input  cfg_t live_cfg,
    output cfg_t shd_cfg
);
    always_ff @(posedge clk) begin
        if (rst || srst_busy)
            shd_cfg <= '0;
        else if (upd_pend)
            shd_cfg <= live_cfg;
    end
endmodule

// File: rtl/cam_rx_irq.sv
`timescale 1ns/1ps
module cam_rx_irq
    import cam_rx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          srst_busy,
    input  logic [DW-1:0] evt_in,
    input  logic [DW-1:0] clr_vec,
    input  logic [DW-1:0] imsk_q,
    output logic [DW-1:0] flags,
    output logic          irq
);
    for (genvar i = 0; i < int'(DW); i++) begin : g_flag
        if (ISRC_IMPL[i]) begin : g_impl
            always_ff @(posedge clk) begin
                if (rst || srst_busy)
                    flags[i] <= 1'b0;
                else if (evt_in[i])
                    flags[i] <= 1'b1;
                else if (clr_vec[i])
                    flags[i] <= 1'b0;
            end
        end else begin : g_none
            assign flags[i] = 1'b0;
        end
    end

    assign irq = |(flags & expand_mask(imsk_q));
endmodule

// File: rtl/cam_rx_regfile.sv
`timescale 1ns/1ps
module cam_rx_regfile
    import cam_rx_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SRST_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [DW-1:0]        evt_in,
    output logic                 core_rst,
    output logic                 rx_enable,
    output logic                 rx_pol_swap,
    output logic                 rx_align32,
    output logic                 rx_ext_clk,
    output logic [LANE_W-1:0]    rx_lane_en,
    output logic [SETTL_W-1:0]   rx_settle,
    output logic [DT_W-1:0]      rx_dtype,
    output logic [NL_W-1:0]      rx_lanes_m1,
    output logic [DIM_W-1:0]     rx_width,
    output logic [DIM_W-1:0]     rx_height,
    output logic                 irq
);
    cfg_t          live_cfg, shd_cfg;
    logic [DW-1:0] imsk_q, clr_vec, isrc_q;
    logic          upd_pend, srst_busy;

    cam_rx_bus_regs #(.ADDR_W(ADDR_W), .SRST_CYCLES(SRST_CYCLES)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .flags(isrc_q), .bus_rdata(bus_rdata),
        .live_cfg(live_cfg), .imsk_q(imsk_q), .clr_vec(clr_vec),
        .upd_pend(upd_pend), .srst_busy(srst_busy)
    );

    cam_rx_shadow u_shadow (
        .clk(clk), .rst(rst), .srst_busy(srst_busy), .upd_pend(upd_pend),
        .live_cfg(live_cfg), .shd_cfg(shd_cfg)
    );

    cam_rx_irq u_irq (
        .clk(clk), .rst(rst), .srst_busy(srst_busy), .evt_in(evt_in),
        .clr_vec(clr_vec), .imsk_q(imsk_q), .flags(isrc_q), .irq(irq)
    );

    assign core_rst    = srst_busy;
    assign rx_enable   = shd_cfg.en;
    assign rx_pol_swap = shd_cfg.swap;
    assign rx_align32  = shd_cfg.align32;
    assign rx_ext_clk  = shd_cfg.extclk;
    assign rx_lane_en  = shd_cfg.lane_en;
    assign rx_settle   = shd_cfg.settle;
    assign rx_dtype    = shd_cfg.dtype;
    assign rx_lanes_m1 = shd_cfg.lanes_m1;
    assign rx_width    = shd_cfg.width;
    assign rx_height   = shd_cfg.height;
endmodule

// File: rtl/cam_rx_regfile_chk.sv
`timescale 1ns/1ps
module cam_rx_regfile_chk
    import cam_rx_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] evt_in,
    input logic          upd_pend,
    input logic          srst_busy,
    input cfg_t          live_cfg,
    input cfg_t          shd_cfg,
    input logic [DW-1:0] flags,
    input logic          irq
);
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!upd_pend && !srst_busy) |=> $stable(shd_cfg)); // R3
    AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (rst)
        (upd_pend && !srst_busy) |=> (shd_cfg == $past(live_cfg))); // R3
    AST_UPD_PULSE: assert property (@(posedge clk) disable iff (rst)
        upd_pend |=> !upd_pend); // R4
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((flags & ~ISRC_IMPL) == '0)); // R5
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
        (!srst_busy && ((evt_in & ISRC_IMPL) != '0))
        |=> ((flags & $past(evt_in & ISRC_IMPL)) == $past(evt_in & ISRC_IMPL))); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (flags == '0) |-> !irq); // R8
    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        srst_busy |=> (flags == '0 && shd_cfg == '0 && !irq)); // R9
    AST_SRST_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(srst_busy) |=> srst_busy); // R9
endmodule

bind cam_rx_regfile cam_rx_regfile_chk u_chk (
    .clk(clk), .rst(rst), .evt_in(evt_in), .upd_pend(upd_pend),
    .srst_busy(srst_busy), .live_cfg(live_cfg), .shd_cfg(shd_cfg),
    .flags(isrc_q), .irq(irq)
);

// File: tb/sim_cam_rx_regfile.sv
`timescale 1ns/1ps
module sim_cam_rx_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] evt_in = '0;
    logic        core_rst, rx_enable, rx_pol_swap, rx_align32, rx_ext_clk, irq;
    logic [4:0]  rx_lane_en, rx_settle;
    logic [5:0]  rx_dtype;
    logic [1:0]  rx_lanes_m1;
    logic [15:0] rx_width, rx_height;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    cam_rx_regfile u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .core_rst(core_rst), .rx_enable(rx_enable), .rx_pol_swap(rx_pol_swap),
        .rx_align32(rx_align32), .rx_ext_clk(rx_ext_clk), .rx_lane_en(rx_lane_en),
        .rx_settle(rx_settle), .rx_dtype(rx_dtype), .rx_lanes_m1(rx_lanes_m1),
        .rx_width(rx_width), .rx_height(rx_height), .irq(irq)
    );

    // {addr, write data, expected read-back}
    localparam logic [71:0] VEC [9] = '{
        {8'h00, 32'hFFFE_FFEF, 32'h8010_0101},
        {8'h04, 32'hFFFF_FFFF, 32'hF800_001F},
        {8'h08, 32'hFFFF_FFFF, 32'h0000_00FF},
        {8'h2C, 32'h1234_5678, 32'h1234_5678},
        {8'h10, 32'hFFFF_FFFF, 32'hF000_103F},
        {8'h14, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h0C, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h2D, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h10, 32'h0000_1000, 32'h0000_1000}
    };

    function automatic logic [63:0] outs();
        return {10'd0, rx_enable, rx_pol_swap, rx_align32, rx_ext_clk, rx_lane_en,
                rx_settle, rx_dtype, rx_lanes_m1, rx_width, rx_height};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk);
        evt_in = e;
        @(negedge clk);
        evt_in = '0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 48; a += 4) begin
            rd(8'(a), v);
            chk("R1 reg", {32'd0, v}, 64'd0);
        end
        chk("R1 irq/core_rst", {62'd0, irq, core_rst}, 64'd0);
        chk("R1 outputs", outs(), 64'd0);

        // R2 read-back table
        for (int i = 0; i < 9; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], v);
            chk("R2 readback", {32'd0, v}, {32'd0, VEC[i][31:0]});
        end

        // R3 no update yet
        chk("R3 held before update", outs(), 64'd0);
        wr(8'h00, 32'h8011_0101);
        chk("R3 not before next cycle", outs(), 64'd0);
        rd(8'h00, v);
        chk("R4 update bit set", {32'd0, v}, 64'h8011_0101);
        @(negedge clk);
        chk("R3 loaded", outs(),
            {10'd0, 1'b1, 1'b1, 1'b1, 1'b1, 5'h1F, 5'h1F, 6'h3F, 2'h3, 16'h1234, 16'h5678});
        rd(8'h00, v);
        chk("R4 update bit cleared", {32'd0, v}, 64'h8010_0101);

        // R3 second pattern
        wr(8'h04, 32'h3000_0003);
        wr(8'h08, 32'h0000_00AD);
        wr(8'h2C, 32'hAAAA_5555);
        @(negedge clk);
        chk("R3 width held", {48'd0, rx_width}, 64'h1234);
        wr(8'h00, 32'h0001_0001);
        @(negedge clk);
        chk("R3 pattern two", outs(),
            {10'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'h03, 5'h06, 6'h2B, 2'h1, 16'hAAAA, 16'h5555});

        // R5 latch regardless of mask, R8 gating
        wr(8'h10, 32'h0);
        pulse(32'hFFFF_FFFF);
        rd(8'h14, v);
        chk("R5 implemented flags", {32'd0, v}, 64'hF000_F03F);
        chk("R8 masked off", {63'd0, irq}, 64'd0);
        wr(8'h10, 32'h0000_1000);
        chk("R8 bit12 covers field", {63'd0, irq}, 64'd1);
        wr(8'h14, 32'h0000_F000);
        rd(8'h14, v);
        chk("R6 clear field", {32'd0, v}, 64'hF000_003F);
        chk("R8 irq drops", {63'd0, irq}, 64'd0);
        wr(8'h10, 32'h0000_0001);
        chk("R8 bit0", {63'd0, irq}, 64'd1);
        wr(8'h14, 32'h0000_0001);
        rd(8'h14, v);
        chk("R6 clear one", {32'd0, v}, 64'hF000_003E);
        chk("R8 bit0 cleared", {63'd0, irq}, 64'd0);
        wr(8'h14, 32'hFFFF_FFFF);
        pulse(32'h0000_4000);
        chk("R8 lane flag unmasked", {63'd0, irq}, 64'd0);
        wr(8'h10, 32'h0000_1000);
        chk("R8 lane flag via bit12", {63'd0, irq}, 64'd1);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, v);
        chk("R6 clear all", {32'd0, v}, 64'd0);

        // R7 event beats clear
        pulse(32'h0000_0018);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h18; evt_in = 32'h08;
        @(negedge clk);
        bus_wr = 1'b0; evt_in = '0;
        rd(8'h14, v);
        chk("R7 event wins", {32'd0, v}, 64'h08);

        // R9 soft reset, R10 events dropped
        wr(8'h10, 32'h0000_0008);
        chk("R9 irq before", {63'd0, irq}, 64'd1);
        wr(8'h00, 32'h0000_0011);
        rd(8'h00, v);
        chk("R9 reset bit reads 1", {32'd0, v}, 64'h11);
        chk("R9 core_rst 1", {63'd0, core_rst}, 64'd1);
        @(negedge clk);
        evt_in = 32'h2;
        chk("R9 core_rst 2", {63'd0, core_rst}, 64'd1);
        rd(8'h14, v);
        chk("R9 flags cleared", {32'd0, v}, 64'd0);
        chk("R9 irq cleared", {63'd0, irq}, 64'd0);
        chk("R9 outputs cleared", outs(), 64'd0);
        @(negedge clk);
        evt_in = '0;
        chk("R9 core_rst 3", {63'd0, core_rst}, 64'd1);
        @(negedge clk);
        chk("R9 core_rst 4", {63'd0, core_rst}, 64'd1);
        @(negedge clk);
        chk("R9 core_rst ends", {63'd0, core_rst}, 64'd0);
        rd(8'h14, v);
        chk("R10 event dropped", {32'd0, v}, 64'd0);
        rd(8'h04, v);
        chk("R9 phy kept", {32'd0, v}, 64'h3000_0003);
        rd(8'h2C, v);
        chk("R9 resol kept", {32'd0, v}, 64'hAAAA_5555);
        rd(8'h10, v);
        chk("R9 mask kept", {32'd0, v}, 64'h8);
        chk("R9 outputs stay cleared", outs(), 64'd0);
        wr(8'h00, 32'h0001_0001);
        @(negedge clk);
        chk("R3 reload after soft reset", outs(),
            {10'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'h03, 5'h06, 6'h2B, 2'h1, 16'hAAAA, 16'h5555});

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule